// File: doc/BRIEF.md
# Per-Pin Programmable Input Debounce Bank

This block cleans up eight slow digital inputs, such as buttons, switches or wake lines, before they reach the rest of the chip. Each input first passes through a two-flop synchroniser. A per-pin counter then watches how long the synchronised level has differed from the pin's current filtered output. Only when the new level has held for the chosen stability period does the filtered output take it. A short glitch, or a bounce that returns to the old level, never reaches the output.

All period counting uses one shared one-cycle tick, produced once per microsecond by a prescaler that divides the system clock by `CLK_PER_US`. Software configures the pins through one 32-bit register made of eight 4-bit fields. Pin n owns bits [4n+3:4n]. The top bit of each field is a per-field write enable, so a single write can retune any subset of pins and leave the others alone. The low three bits pick a period from a fixed table that runs from 1 µs to 30 ms.

Top module: `pin_debounce_bank`

## Requirements
- R1: After reset every select field reads 0, every filtered output is 0 and the readback word is 0.
- R2: Pin n's field is bits [4n+3:4n] of the write data. Bit 4n+3 is that field's write enable. A write changes pin n's select value only when bit 4n+3 is 1, and fields whose enable bit is 0 keep their value.
- R3: The readback word places pin n's 3-bit select value in bits [4n+2:4n], and bit 4n+3 always reads 0. A write appears in the readback from the next clock cycle on.
- R4: Select codes map to stability periods as follows: 0 = 1 µs, 1 = 10 µs, 2 = 100 µs, 3 = 1 ms, 4 = 10 ms, 5 = 20 ms, 6 = 30 ms.
- R5: Select code 7 is reserved and behaves exactly like code 6, giving 30 ms.
- R6: A one-cycle tick occurs every `CLK_PER_US` clock cycles, and all periods are counted in these ticks, so a period of N µs is N ticks.
- R7: When a raw input moves to a new level and holds there, the filtered output takes that level no earlier than (N−1)·`CLK_PER_US`+2 cycles and no later than N·`CLK_PER_US`+3 cycles after the change. This applies to both rising and falling transitions.
- R8: A new level that returns to the filtered value before its period has elapsed leaves the output unchanged. The next departure counts again from zero.
- R9: A write whose enable bit is set for pin n restarts pin n's count from zero under the new period, even if a count is already partly done.
- R10: Pins filter independently. A transition on one pin, or a write to one pin's field, does not alter any other pin's output timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wr_data | input | 32 | Write data: eight 4-bit fields, each with its enable bit on top |
| cfg_rd_data | output | 32 | Readback: select codes with the enable positions read as 0 |
| pin_raw | input | 8 | Unsynchronised raw inputs |
| pin_filt | output | 8 | Debounced outputs |

## Verification
The hardest situation to reach from the ports is a count that is already well under way when the pin's period is shortened. Without a restart, the stale count already exceeds the new limit. To get there, the stimulus raises a pin set to 1 ms and waits three quarters of that period. It then rewrites only that pin's field to 100 µs and checks that the output stays low for most of the new period before it switches. The 30 ms codes, including reserved code 7, need very long windows. Four pins with the four longest settings therefore share a single rising edge, and each output is bracketed on both sides of its own deadline.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  localparam int SEL_W   = 3;
  localparam int FIELD_W = 4;
  localparam int MAX_US  = 30000;
  localparam int CNT_W   = $clog2(MAX_US + 1);

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Period in microsecond ticks for a select code; the reserved code folds onto the longest.
  function automatic cnt_t sel_to_ticks(sel_t code);
    cnt_t t;
    case (code)
      3'd0:    t = cnt_t'(1);
      3'd1:    t = cnt_t'(10);
      3'd2:    t = cnt_t'(100);
      3'd3:    t = cnt_t'(1000);
      3'd4:    t = cnt_t'(10000);
      3'd5:    t = cnt_t'(20000);
      default: t = cnt_t'(MAX_US);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (div_q == DIV_LAST) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
      tick_q <= (div_q == DIV_LAST);
    end
  end

  assign tick = tick_q;

  generate
    if (CLK_PER_US > 1) begin : g_gap_chk
      // R6: with a divider above one, ticks are never back to back
      p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q)
        else $error("tick repeated in consecutive cycles");
    end
  endgenerate

endmodule

// File: rtl/dbnc_cfg_reg.sv
module dbnc_cfg_reg
  import dbnc_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [NUM_PINS*FIELD_W-1:0]   wr_data,
  output logic [NUM_PINS*FIELD_W-1:0]   rd_data,
  output sel_t [NUM_PINS-1:0]           sel,
  output logic [NUM_PINS-1:0]           restart
);

  sel_t [NUM_PINS-1:0] sel_q;

  genvar n;
  generate
    for (n = 0; n < NUM_PINS; n++) begin : g_field
      localparam int LO = n * FIELD_W;
      localparam int WE = LO + FIELD_W - 1;

      logic fld_we;
      assign fld_we = wr_en & wr_data[WE];

      always_ff @(posedge clk) begin
        if (rst)         sel_q[n] <= '0;
        else if (fld_we) sel_q[n] <= wr_data[LO +: SEL_W];
      end

      assign restart[n]            = fld_we;
      assign rd_data[LO +: FIELD_W] = {1'b0, sel_q[n]};

      // R2: a field whose enable bit is clear keeps its value
      p_field_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[WE]) |=> (sel_q[n] == $past(sel_q[n])))
        else $error("field %0d changed without its enable", n);

      // R2: a field whose enable bit is set takes the written code
      p_field_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[WE]) |=> (sel_q[n] == $past(wr_data[LO +: SEL_W])))
        else $error("field %0d did not load", n);
    end
  endgenerate

  assign sel = sel_q;

endmodule

// File: rtl/dbnc_pin_filter.sv
module dbnc_pin_filter
  import dbnc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  sel_t sel,
  input  logic raw,
  output logic filt
);

  logic meta_q;
  logic sync_q;
  logic filt_q;
  cnt_t cnt_q;
  cnt_t limit;
  logic differ;

  assign limit  = sel_to_ticks(sel);
  assign differ = (sync_q != filt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (restart || !differ) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= limit - 1'b1) begin
        filt_q <= sync_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt = filt_q;

  // R6: the filtered level moves only on a tick cycle
  p_flip_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> $past(tick))
    else $error("output moved without a tick");

  // R7: the filtered level only ever moves toward the synchronised level
  p_flip_to_sync_r7: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_q)))
    else $error("output moved away from input");

  // R8: agreement between input and output clears the count
  p_agree_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (sync_q == filt_q && !restart) |=> (cnt_q == '0))
    else $error("count kept while input agreed");

  // R9: a field write clears the count
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0))
    else $error("count not cleared by field write");

  // R9: the count never exceeds the active period
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit)
    else $error("count beyond period");

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
  import dbnc_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int CLK_PER_US = 200
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr_en,
  input  logic [NUM_PINS*FIELD_W-1:0] cfg_wr_data,
  output logic [NUM_PINS*FIELD_W-1:0] cfg_rd_data,
  input  logic [NUM_PINS-1:0]         pin_raw,
  output logic [NUM_PINS-1:0]         pin_filt
);

  logic                tick;
  sel_t [NUM_PINS-1:0] sel;
  logic [NUM_PINS-1:0] restart;

  dbnc_tick_gen #(
    .CLK_PER_US(CLK_PER_US)
  ) i_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  dbnc_cfg_reg #(
    .NUM_PINS(NUM_PINS)
  ) i_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data),
    .sel    (sel),
    .restart(restart)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      dbnc_pin_filter i_filt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .restart(restart[p]),
        .sel    (sel[p]),
        .raw    (pin_raw[p]),
        .filt   (pin_filt[p])
      );
    end
  endgenerate

  // R1: outputs and readback stay cleared during reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (pin_filt == '0 && cfg_rd_data == '0))
    else $error("state not cleared by reset");

endmodule

// File: tb/test_pin_debounce_bank.sv
module test_pin_debounce_bank;

  localparam int NP  = 8;
  localparam int CPU = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [31:0]   cfg_wr_data = '0;
  logic [31:0]   cfg_rd_data;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_filt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pin_debounce_bank #(.NUM_PINS(NP), .CLK_PER_US(CPU)) i_pin_debounce_bank (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
  endtask

  function automatic logic [31:0] pin_field(input int pin, input int code);
    return (32'(8 | code)) << (4 * pin);
  endfunction

  function automatic int ticks_of(input int code);
    case (code)
      0: return 1;
      1: return 10;
      2: return 100;
      3: return 1000;
      4: return 10000;
      5: return 20000;
      default: return 30000;
    endcase
  endfunction

  task automatic t_reset;
    check(pin_filt == '0, "R1 outputs after reset", pin_filt, 0);
    check(cfg_rd_data == '0, "R1 readback after reset", cfg_rd_data, 0);
  endtask

  task automatic t_write_mask;
    cfg_write(32'h0000_00AB);
    check(cfg_rd_data == 32'h0000_0023, "R2 R3 enabled fields load", cfg_rd_data, 32'h23);
    cfg_write(32'hFFFF_FF07);
    check(cfg_rd_data == 32'h7777_7723, "R2 field0 without enable keeps", cfg_rd_data, 32'h7777_7723);
    check((cfg_rd_data & 32'h8888_8888) == 0, "R3 enable bits read zero", cfg_rd_data, 0);
    check(pin_filt == '0, "R2 writes leave outputs", pin_filt, 0);
    cfg_write(32'h8888_8888);
    check(cfg_rd_data == 32'h0, "R2 all fields cleared", cfg_rd_data, 0);
  endtask

  // One pin, one code: rising then falling edge bracketed on both sides
  task automatic t_period(input int pin, input int code);
    int n = ticks_of(code);
    int early = (n - 1) * CPU + 1;
    int late  = n * CPU + 4;
    cfg_write(pin_field(pin, code));
    for (int lvl = 1; lvl >= 0; lvl--) begin
      @(negedge clk);
      pin_raw[pin] = lvl[0];
      wait_cyc(early);
      check(pin_filt[pin] == !lvl[0], "R4 R7 output held before period", pin_filt[pin], !lvl[0]);
      wait_cyc(late - early);
      check(pin_filt[pin] == lvl[0], "R4 R7 output follows after period", pin_filt[pin], lvl[0]);
    end
  endtask

  task automatic t_glitch;
    cfg_write(pin_field(2, 2));
    @(negedge clk);
    pin_raw[2] = 1'b1;
    wait_cyc(150);
    pin_raw[2] = 1'b0;
    wait_cyc(300);
    check(pin_filt[2] == 1'b0, "R8 short pulse ignored", pin_filt[2], 0);
    pin_raw[2] = 1'b1;
    wait_cyc(150);
    pin_raw[2] = 1'b0;
    wait_cyc(2);
    pin_raw[2] = 1'b1;
    wait_cyc(150);
    check(pin_filt[2] == 1'b0, "R8 count restarts after dip", pin_filt[2], 0);
    wait_cyc(54);
    check(pin_filt[2] == 1'b1, "R8 output follows after full period", pin_filt[2], 1);
    pin_raw[2] = 1'b0;
    wait_cyc(210);
  endtask

  task automatic t_cfg_restart;
    cfg_write(pin_field(3, 3));
    @(negedge clk);
    pin_raw[3] = 1'b1;
    wait_cyc(1500);
    check(pin_filt[3] == 1'b0, "R9 partial count before rewrite", pin_filt[3], 0);
    cfg_write(pin_field(3, 2));
    wait_cyc(100);
    check(pin_filt[3] == 1'b0, "R9 rewrite restarts count", pin_filt[3], 0);
    wait_cyc(106);
    check(pin_filt[3] == 1'b1, "R9 output follows under new period", pin_filt[3], 1);
    check(pin_filt[2:0] == 3'b000, "R10 other pins untouched", pin_filt[2:0], 0);
  endtask

  task automatic t_long_parallel;
    cfg_write(pin_field(4, 4) | pin_field(5, 5) | pin_field(6, 6) | pin_field(7, 7));
    check(cfg_rd_data[31:16] == 16'h7654, "R3 readback of long codes", cfg_rd_data[31:16], 16'h7654);
    @(negedge clk);
    pin_raw[7:4] = 4'hF;
    wait_cyc(19999);
    check(pin_filt[7:4] == 4'h0, "R4 10ms held", pin_filt[7:4], 0);
    wait_cyc(5);
    check(pin_filt[7:4] == 4'h1, "R4 R10 10ms pin alone follows", pin_filt[7:4], 1);
    wait_cyc(19995);
    check(pin_filt[7:4] == 4'h1, "R4 20ms held", pin_filt[7:4], 1);
    wait_cyc(5);
    check(pin_filt[7:4] == 4'h3, "R4 20ms follows", pin_filt[7:4], 3);
    wait_cyc(19995);
    check(pin_filt[7:4] == 4'h3, "R4 R5 30ms and code 7 held", pin_filt[7:4], 3);
    wait_cyc(5);
    check(pin_filt[7:4] == 4'hF, "R5 code 7 matches 30ms", pin_filt[7:4], 15);
  endtask

  initial begin
    wait_cyc(4);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_mask();
    t_period(0, 0);   // R6 tick spacing shows in 1 us and 10 us periods
    t_period(1, 1);
    t_glitch();
    t_cfg_restart();
    t_long_parallel();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule